// File: doc/BRIEF.md
# Segment Table Associative Search

This block keeps a table of segment translation entries and searches all of them at once for one effective address. It carries out the datapath of a privileged "find entry by address" operation. A start strobe with a 64-bit address begins a search. One clock later the block returns a 64-bit word with the attributes of the matching entry, a 4-bit condition field, and a done pulse.

Each entry matches over a number of address bits set by its own segment-size field. An entry also matches only when one fixed address bit equals its tag-active flag. The search is refused in user mode, and more than one matching entry is reported as an error. Entries are loaded through a simple indexed write port. A write becomes visible to the first search started after the clock edge that stores it.

Top module: `seg_search_unit`

## Requirements
- R1: After synchronous reset, done, priv_exc, multi_err, result and cond are all zero, and every entry is invalid, so no search finds a match.
- R2: An entry written with valid low never matches.
- R3: Segment size 0 (256 MB) compares address bits [63:28] with all 36 tag bits. Segment size 1 (1 TB) compares address bits [63:40] with tag bits [35:12] and ignores tag bits [11:0]. Segment sizes 2 and 3 never match.
- R4: An entry matches only when address bit 24 (counted from the LSB) equals the entry's tag-active flag.
- R5: With exactly one match, result is {ssize[1:0], vsid[49:0], kp_s, kp_p, nx, lp, cls, ta, lps[1:0], 4'b0000}, with bit 63 on the left.
- R6: With no match, result is zero and the EQ bit is clear.
- R7: On a completed search, cond[3:2] is 0, cond[1] (EQ) is 1 only for a single match, and cond[0] copies so_in from the start cycle.
- R8: When mode64 is low, address bits [63:32] are treated as zero for the search.
- R9: With two or more matches, multi_err pulses together with done. Result and cond are then don't-care.
- R10: A start with user high gives a one-cycle priv_exc pulse one clock later, with no done. Result and cond keep their previous values.
- R11: Done pulses exactly one clock after a supervisor start. A table write updates the entry at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Search strobe |
| ea | input | 64 | Effective address operand |
| mode64 | input | 1 | 64-bit mode; when low, the upper address half is zeroed |
| user | input | 1 | High when the requester is in user mode |
| so_in | input | 1 | Summary-overflow bit copied into cond[0] |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 5 | Entry index to write |
| wr_valid | input | 1 | Valid flag of the written entry |
| wr_ssize | input | 2 | Segment size code |
| wr_tag | input | 36 | Effective segment tag |
| wr_vsid | input | 50 | Virtual segment ID |
| wr_kp_s | input | 1 | Supervisor protection key |
| wr_kp_p | input | 1 | Problem-state protection key |
| wr_nx | input | 1 | No-execute flag |
| wr_lp | input | 1 | Large-page flag |
| wr_cls | input | 1 | Class flag |
| wr_ta | input | 1 | Tag-active flag |
| wr_lps | input | 2 | Page-size select |
| done | output | 1 | Search completed pulse |
| result | output | 64 | Packed attributes of the matching entry |
| cond | output | 4 | Condition field: {LT, GT, EQ, SO} |
| priv_exc | output | 1 | Illegal-privilege pulse |
| multi_err | output | 1 | Multiple-match error pulse |

## Verification
The assertions assume that start is a single-cycle strobe and that no table write targets the table in the same cycle as a start. Under those assumptions the result seen one clock later matches the table contents at the start. The stimulus keeps to this by separating each write from each search with a full clock cycle. It also runs a user-mode search only after a search whose result is defined, so the held value can be compared.

// File: rtl/seg_search_pkg.sv
package seg_search_pkg;
  localparam int EA_W     = 64;
  localparam int TAG_W    = 36;
  localparam int VSID_W   = 50;
  localparam int RES_W    = 64;
  localparam int SH_256M  = 28;
  localparam int SH_1T    = 40;
  localparam int TA_BIT   = 24;
  localparam logic [1:0] SZ_256M = 2'd0;
  localparam logic [1:0] SZ_1T   = 2'd1;

  typedef struct packed {
    logic [1:0]        ssize;
    logic [TAG_W-1:0]  tag;
    logic [VSID_W-1:0] vsid;
    logic              kp_s;
    logic              kp_p;
    logic              nx;
    logic              lp;
    logic              cls;
    logic              ta;
    logic [1:0]        lps;
  } seg_entry_t;

  localparam int PAY_W = 2 + VSID_W + 8;
  localparam int PAD_W = RES_W - PAY_W;
endpackage

// File: rtl/seg_entry_table.sv
module seg_entry_table
  import seg_search_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_valid,
  input  seg_entry_t            wr_data,
  output logic [ENTRIES-1:0]    valid,
  output seg_entry_t            entries [ENTRIES]
);
  // Valid bits need reset; payload is plain storage without reset.
  always_ff @(posedge clk) begin
    if (rst) valid <= '0;
    else if (wr_en) valid[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) entries[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/seg_match_array.sv
module seg_match_array
  import seg_search_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [EA_W-1:SH_256M]   ea_seg,
  input  logic                    ea_ta,
  input  logic [ENTRIES-1:0]      valid,
  input  seg_entry_t              entries [ENTRIES],
  output logic [ENTRIES-1:0]      hit
);
  localparam int NARROW_LO = SH_1T - SH_256M;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic seg_eq;
    always_comb begin
      unique case (entries[i].ssize)
        SZ_256M: seg_eq = (ea_seg == entries[i].tag);
        SZ_1T:   seg_eq = (ea_seg[EA_W-1:SH_1T] == entries[i].tag[TAG_W-1:NARROW_LO]);
        default: seg_eq = 1'b0;
      endcase
    end
    assign hit[i] = valid[i] && seg_eq && (ea_ta == entries[i].ta);

    // R3: reserved size codes must never produce a hit
    p_bad_size_nohit_r3: assert property (@(posedge clk) disable iff (rst)
      hit[i] |-> (entries[i].ssize == SZ_256M || entries[i].ssize == SZ_1T));
  end
endmodule

// File: rtl/seg_hit_encoder.sv
module seg_hit_encoder
  import seg_search_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0] hit,
  input  seg_entry_t         entries [ENTRIES],
  output logic               single,
  output logic               multi,
  output logic [RES_W-1:0]   word
);
  logic [CNT_W-1:0] cnt;
  seg_entry_t       sel;

  // AND-OR selection: valid when exactly one hit bit is set
  always_comb begin
    cnt = '0;
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      cnt = cnt + CNT_W'(hit[i]);
      if (hit[i]) sel = sel | entries[i];
    end
  end

  assign single = (cnt == CNT_W'(1));
  assign multi  = (cnt > CNT_W'(1));
  assign word   = {sel.ssize, sel.vsid, sel.kp_s, sel.kp_p, sel.nx, sel.lp,
                   sel.cls, sel.ta, sel.lps, {PAD_W{1'b0}}};
endmodule

// File: rtl/seg_search_unit.sv
module seg_search_unit
  import seg_search_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [63:0]          ea,
  input  logic                 mode64,
  input  logic                 user,
  input  logic                 so_in,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_valid,
  input  logic [1:0]           wr_ssize,
  input  logic [35:0]          wr_tag,
  input  logic [49:0]          wr_vsid,
  input  logic                 wr_kp_s,
  input  logic                 wr_kp_p,
  input  logic                 wr_nx,
  input  logic                 wr_lp,
  input  logic                 wr_cls,
  input  logic                 wr_ta,
  input  logic [1:0]           wr_lps,
  output logic                 done,
  output logic [63:0]          result,
  output logic [3:0]           cond,
  output logic                 priv_exc,
  output logic                 multi_err
);
  seg_entry_t         wr_data;
  seg_entry_t         entries [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] hit;
  logic [EA_W-1:0]    ea_eff;
  logic               single, multi;
  logic [RES_W-1:0]   word;

  assign wr_data = '{ssize: wr_ssize, tag: wr_tag, vsid: wr_vsid, kp_s: wr_kp_s,
                     kp_p: wr_kp_p, nx: wr_nx, lp: wr_lp, cls: wr_cls,
                     ta: wr_ta, lps: wr_lps};

  assign ea_eff = mode64 ? ea : {32'h0, ea[31:0]};

  seg_entry_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_data(wr_data), .valid(valid), .entries(entries));

  seg_match_array #(.ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst(rst), .ea_seg(ea_eff[EA_W-1:SH_256M]), .ea_ta(ea_eff[TA_BIT]),
    .valid(valid), .entries(entries), .hit(hit));

  seg_hit_encoder #(.ENTRIES(ENTRIES)) u_enc (
    .hit(hit), .entries(entries), .single(single), .multi(multi), .word(word));

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      priv_exc  <= 1'b0;
      multi_err <= 1'b0;
      result    <= '0;
      cond      <= '0;
    end else begin
      done      <= 1'b0;
      priv_exc  <= 1'b0;
      multi_err <= 1'b0;
      if (start) begin
        if (user) begin
          priv_exc <= 1'b1;
        end else begin
          done      <= 1'b1;
          multi_err <= multi;
          result    <= single ? word : '0;
          cond      <= {2'b00, single, so_in};
        end
      end
    end
  end

  // R10: a user-mode request faults and leaves the outputs untouched
  p_user_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (start && user) |=> (priv_exc && !done));
  p_user_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (start && user) |=> ($stable(result) && $stable(cond)));
  // R11: completion one clock after a supervisor start, never spontaneously
  p_done_latency_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !user) |=> done);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && !priv_exc));
  // R7: upper condition bits stay clear
  p_cond_upper_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cond[3:2] == 2'b00));
  // R6: a miss returns a zero word
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !multi_err && !cond[1]) |-> (result == '0));
  // R9: the error only accompanies a completed search
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    multi_err |-> done);
endmodule

// File: tb/seg_search_unit_tb.sv
module seg_search_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 0, mode64 = 1, user = 0, so_in = 0;
  logic [63:0] ea = '0;
  logic        wr_en = 0, wr_valid = 0;
  logic [4:0]  wr_idx = '0;
  logic [1:0]  wr_ssize = '0, wr_lps = '0;
  logic [35:0] wr_tag = '0;
  logic [49:0] wr_vsid = '0;
  logic        wr_kp_s = 0, wr_kp_p = 0, wr_nx = 0, wr_lp = 0, wr_cls = 0, wr_ta = 0;
  logic        done, priv_exc, multi_err;
  logic [63:0] result;
  logic [3:0]  cond;

  always #2.5 clk = ~clk;

  seg_search_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .ea(ea), .mode64(mode64), .user(user),
    .so_in(so_in), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_ssize(wr_ssize), .wr_tag(wr_tag), .wr_vsid(wr_vsid), .wr_kp_s(wr_kp_s),
    .wr_kp_p(wr_kp_p), .wr_nx(wr_nx), .wr_lp(wr_lp), .wr_cls(wr_cls), .wr_ta(wr_ta),
    .wr_lps(wr_lps), .done(done), .result(result), .cond(cond),
    .priv_exc(priv_exc), .multi_err(multi_err));

  typedef struct {
    logic        v;
    logic [1:0]  ssize;
    logic [35:0] tag;
    logic [49:0] vsid;
    logic [5:0]  flags;   // kp_s kp_p nx lp cls ta
    logic [1:0]  lps;
  } ment_t;

  typedef struct {
    logic        priv;
    logic        err;
    logic        check_data;
    logic [63:0] res;
    logic [3:0]  cnd;
    string       tag;
  } exp_t;

  ment_t model [32];
  exp_t  sb [$];
  int    checks = 0, errors = 0;
  logic [63:0] last_res = '0;
  logic [3:0]  last_cnd = '0;
  logic        last_known = 1'b1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic v, input logic [1:0] sz, input logic [35:0] tg,
                    input logic [49:0] vs, input logic [5:0] fl, input logic [1:0] ps);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_valid = v; wr_ssize = sz; wr_tag = tg; wr_vsid = vs;
    {wr_kp_s, wr_kp_p, wr_nx, wr_lp, wr_cls, wr_ta} = fl; wr_lps = ps;
    @(negedge clk);
    wr_en = 0;
    model[idx] = '{v, sz, tg, vs, fl, ps};
  endtask

  // Driver: compute expectation from the requirements and push it
  task automatic lookup(input logic [63:0] a, input logic m64, input logic u,
                        input logic so, input string tag);
    exp_t e;
    logic [63:0] ee;
    int n;
    ment_t hitent;
    ee = m64 ? a : {32'h0, a[31:0]};
    n = 0;
    hitent = model[0];
    for (int i = 0; i < 32; i++) begin
      logic seg;
      seg = (model[i].ssize == 2'd0) ? (ee[63:28] == model[i].tag) :
            (model[i].ssize == 2'd1) ? (ee[63:40] == model[i].tag[35:12]) : 1'b0;
      if (model[i].v && seg && ee[24] == model[i].flags[0]) begin
        n++;
        hitent = model[i];
      end
    end
    e.tag = tag;
    if (u) begin
      e.priv = 1; e.err = 0; e.check_data = last_known; e.res = last_res; e.cnd = last_cnd;
    end else begin
      e.priv = 0; e.err = (n > 1); e.check_data = (n <= 1);
      e.res = (n == 1) ? {hitent.ssize, hitent.vsid, hitent.flags, hitent.lps, 4'h0} : 64'h0;
      e.cnd = {2'b00, (n == 1), so};
      last_res = e.res; last_cnd = e.cnd; last_known = (n <= 1);
    end
    sb.push_back(e);
    @(negedge clk);
    start = 1; ea = a; mode64 = m64; user = u; so_in = so;
    @(negedge clk);
    start = 0; user = 0;
  endtask

  // Monitor: pop and compare on every completion or fault
  always @(negedge clk) begin
    if (!rst && (done || priv_exc)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected output", {62'h0, done, priv_exc}, 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(priv_exc == e.priv && done == !e.priv, {e.tag, " R10/R11 kind"},
            {62'h0, done, priv_exc}, {62'h0, !e.priv, e.priv});
        chk(multi_err == e.err, {e.tag, " R9 err"}, {63'h0, multi_err}, {63'h0, e.err});
        if (e.check_data) begin
          chk(result == e.res, {e.tag, " result"}, result, e.res);
          chk(cond == e.cnd, {e.tag, " R7 cond"}, {60'h0, cond}, {60'h0, e.cnd});
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 64'h0, 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '{1'b0, 2'd0, 36'h0, 50'h0, 6'h0, 2'd0};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(!done && !priv_exc && !multi_err && result == 0 && cond == 0, "R1 reset outputs",
        {result[59:0], cond}, 64'h0);
    lookup(64'h0, 1, 0, 0, "R1 empty table");
    // R5 R3 R11: 256 MB entry, lookup right after write
    wr(0, 1, 2'd0, 36'h123456789, 50'h2_ABCD_1234_5678, 6'b101010, 2'd2);
    lookup(64'h1234_5678_9000_0000, 1, 0, 0, "R5 single hit");
    lookup(64'h1234_5678_9ECF_FFFF, 1, 0, 1, "R3 offset ignored");
    // R4 R6: tag-active bit mismatch
    lookup(64'h1234_5678_9100_0000, 1, 0, 1, "R4 ta mismatch");
    lookup(64'h1234_5678_8000_0000, 1, 0, 0, "R6 miss");
    // R3: 1 TB entry ignores low tag bits
    wr(1, 1, 2'd1, 36'hABCDEF_5A5, 50'h1_1111_2222_3333, 6'b010101, 2'd1);
    lookup(64'hABCD_EF12_3456_7890 | 64'h0100_0000, 1, 0, 0, "R3 1TB hit");
    lookup(64'hABCD_EF12_3456_7890 & ~64'h0100_0000, 1, 0, 0, "R4 1TB ta");
    // R3: reserved size never matches
    wr(2, 1, 2'd2, 36'h777777777, 50'h5, 6'b000000, 2'd0);
    lookup(64'h7777_7777_7000_0000, 1, 0, 0, "R3 reserved size");
    wr(6, 1, 2'd3, 36'h666666666, 50'h6, 6'b000000, 2'd0);
    lookup(64'h6666_6666_6000_0000, 1, 0, 0, "R3 size 3");
    // R2: invalid entry
    wr(3, 0, 2'd0, 36'h333333333, 50'h3, 6'b000000, 2'd0);
    lookup(64'h3333_3333_3000_0000, 1, 0, 0, "R2 invalid");
    // R8: 32-bit mode zeroes upper half
    wr(4, 1, 2'd0, 36'h000000005, 50'h3_0000_0000_0004, 6'b111110, 2'd3);
    lookup(64'hFFFF_FFFF_5000_0000, 0, 0, 1, "R8 narrow mode hit");
    lookup(64'hFFFF_FFFF_5000_0000, 1, 0, 1, "R8 wide mode miss");
    // R10: user mode keeps previous outputs
    lookup(64'h1234_5678_9000_0000, 1, 1, 0, "R10 user fault");
    // R9: duplicate entry
    wr(5, 1, 2'd0, 36'h123456789, 50'h9, 6'b000000, 2'd0);
    lookup(64'h1234_5678_9000_0000, 1, 0, 0, "R9 multi");
    // R11: write takes effect, removing the duplicate
    wr(5, 0, 2'd0, 36'h123456789, 50'h9, 6'b000000, 2'd0);
    lookup(64'h1234_5678_9000_0000, 1, 0, 1, "R11 after rewrite");
    // R5: fill every slot with a distinct 256 MB entry and hit each
    for (int i = 0; i < 32; i++)
      wr(i, 1, 2'd0, 36'h800000000 | 36'(i * 37), 50'(i * 50'h1_0203_0405) ^ 50'h2_AAAA_5555_AAAA,
         6'(i * 11) & 6'b111110, 2'(i));
    for (int i = 0; i < 32; i++)
      lookup({36'h800000000 | 36'(i * 37), 28'h00A_BCDE}, 1, 0, i[0], "R5 full table");
    // R1: reset clears all valid bits
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 32; i++) model[i].v = 1'b0;
    last_res = '0; last_cnd = '0; last_known = 1'b1;
    lookup({36'h800000000, 28'h0}, 1, 0, 0, "R1 reset clears table");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 pending results", 64'(sb.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule